// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block is the hazard logic of a five-stage in-order pipeline: fetch, decode/register read, execute, memory and write-back. Every cycle it looks at the instruction in decode and at the instructions still in the execute and memory stages. If decode wants to read a register that one of those later instructions has not yet written, the block freezes the instruction pointer and the decode stage. It also sends a bubble into execute. The stall lasts until the writer has left the memory stage.

The register file writes before it reads within a cycle, so a writer in write-back is already visible to decode and is never compared. Only the operand fields that the decode opcode really uses as registers are compared. Immediate values, jump addresses and destination fields therefore never cause a stall.

The block also resolves jumps in execute. A taken jump raises flush, which squashes the fetch and decode stages. The instruction pointer loads the target on the next rising edge. All outputs are combinational in the cycle the inputs are presented. When a taken jump and a stall occur together, the jump takes priority.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: When decode is valid and an operand it uses as a register equals `ex_dst`, while `ex_valid` and `ex_wr_en` are both 1, then `ip_hold`, `dec_hold` and `bubble` are all 1 in that cycle.
- R2: When decode is valid and a used register operand equals `mem_dst`, while `mem_valid` and `mem_wr_en` are both 1, then `ip_hold`, `dec_hold` and `bubble` are all 1. The write-back stage is never compared, so once the writer leaves the memory stage the stall ends.
- R3: No stall occurs when `dec_valid` is 0, when the matching stage is not valid, or when its write flag is 0. Under reset with idle inputs all four outputs are 0.
- R4: The two-source opcodes read fields B and C. These are add 0x01, multiply 0x02, subtract 0x03, divide 0x04 and the compares 0x09 to 0x0D. Copy 0x05 reads only B. Field A is their destination and never causes a stall.
- R5: Load-immediate 0x06 and jump 0x0E read no register. Memory write 0x07 reads A (base) and C (data). Memory read 0x08 reads only B, and its A field is a destination. Conditional jump 0x0F reads only C. Register jump 0x10 reads only A.
- R6: A valid instruction in execute with opcode 0x0E or 0x10 is a taken jump. In that cycle `flush` and `bubble` are 1, and `ip_hold` and `dec_hold` are 0.
- R7: A valid conditional jump (0x0F) in execute is taken only when `ex_test` is zero. With a non-zero value, `flush` stays 0.
- R8: When a taken jump and a data hazard occur in the same cycle, the flush wins. The outputs are `flush`=1, `bubble`=1, `ip_hold`=0 and `dec_hold`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_op | input | OP_W | Opcode in decode |
| dec_fa | input | RA_W | Operand field A in decode |
| dec_fb | input | RA_W | Operand field B in decode |
| dec_fc | input | RA_W | Operand field C in decode |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_op | input | OP_W | Opcode in execute |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_dst | input | RA_W | Destination register in execute |
| ex_test | input | DATA_W | Register value tested by a conditional jump in execute |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | RA_W | Destination register in memory stage |
| ip_hold | output | 1 | Freeze the instruction pointer |
| dec_hold | output | 1 | Freeze the decode stage |
| bubble | output | 1 | Inject a no-operation into execute |
| flush | output | 1 | Squash fetch and decode; jump target loads next edge |

## Verification
The table drives decode opcodes from every usage class against writers placed in execute or in memory. A writer is matched in turn to field A, B and C, so a wrong operand-usage decode shows up as a missed or a spurious stall. Some vectors turn off the writer's valid or write flag, or decode's valid, which isolates the qualification terms. Further vectors cover each jump kind with a zero and a non-zero test value, and a jump that coincides with a hazard, which separates the taken/not-taken decision from the priority rule. A directed sequence then moves one writer from execute to memory and then out of the memory stage, and the stall is expected to last exactly two cycles.

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl #(
  parameter int OP_W   = 5,
  parameter int RA_W   = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [OP_W-1:0]   dec_op,
  input  logic [RA_W-1:0]   dec_fa,
  input  logic [RA_W-1:0]   dec_fb,
  input  logic [RA_W-1:0]   dec_fc,
  input  logic              ex_valid,
  input  logic [OP_W-1:0]   ex_op,
  input  logic              ex_wr_en,
  input  logic [RA_W-1:0]   ex_dst,
  input  logic [DATA_W-1:0] ex_test,
  input  logic              mem_valid,
  input  logic              mem_wr_en,
  input  logic [RA_W-1:0]   mem_dst,
  output logic              ip_hold,
  output logic              dec_hold,
  output logic              bubble,
  output logic              flush
);

  localparam logic [OP_W-1:0] OP_ADD  = OP_W'(8'h01);
  localparam logic [OP_W-1:0] OP_DIV  = OP_W'(8'h04);
  localparam logic [OP_W-1:0] OP_COPY = OP_W'(8'h05);
  localparam logic [OP_W-1:0] OP_IMM  = OP_W'(8'h06);
  localparam logic [OP_W-1:0] OP_MWR  = OP_W'(8'h07);
  localparam logic [OP_W-1:0] OP_MRD  = OP_W'(8'h08);
  localparam logic [OP_W-1:0] OP_CMPL = OP_W'(8'h09);
  localparam logic [OP_W-1:0] OP_CMPH = OP_W'(8'h0D);
  localparam logic [OP_W-1:0] OP_JMP  = OP_W'(8'h0E);
  localparam logic [OP_W-1:0] OP_JZ   = OP_W'(8'h0F);
  localparam logic [OP_W-1:0] OP_JREG = OP_W'(8'h10);

  logic use_a, use_b, use_c;

  always_comb begin
    use_a = 1'b0;
    use_b = 1'b0;
    use_c = 1'b0;
    if ((dec_op >= OP_ADD && dec_op <= OP_DIV) ||
        (dec_op >= OP_CMPL && dec_op <= OP_CMPH)) begin
      use_b = 1'b1;
      use_c = 1'b1;
    end else begin
      case (dec_op)
        OP_COPY: use_b = 1'b1;
        OP_MWR:  begin use_a = 1'b1; use_c = 1'b1; end
        OP_MRD:  use_b = 1'b1;
        OP_JZ:   use_c = 1'b1;
        OP_JREG: use_a = 1'b1;
        default: ;
      endcase
    end
  end

  wire ex_live  = ex_valid  & ex_wr_en;
  wire mem_live = mem_valid & mem_wr_en;

  wire hit_a = use_a & ((ex_live & (ex_dst == dec_fa)) | (mem_live & (mem_dst == dec_fa)));
  wire hit_b = use_b & ((ex_live & (ex_dst == dec_fb)) | (mem_live & (mem_dst == dec_fb)));
  wire hit_c = use_c & ((ex_live & (ex_dst == dec_fc)) | (mem_live & (mem_dst == dec_fc)));

  wire raw = dec_valid & (hit_a | hit_b | hit_c);

  wire taken = ex_valid & ((ex_op == OP_JMP) | (ex_op == OP_JREG) |
                           ((ex_op == OP_JZ) & (ex_test == '0)));

  wire stall = raw & ~taken;

  assign flush    = taken;
  assign ip_hold  = stall;
  assign dec_hold = stall;
  assign bubble   = stall | taken;

  assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!ip_hold && !dec_hold && bubble));

  assert_hold_needs_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ip_hold |-> (dec_valid && (ex_live || mem_live)));

  assert_imm_never_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == OP_IMM || dec_op == OP_JMP) |-> !dec_hold);

  assert_jump_flushes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && (ex_op == OP_JMP || ex_op == OP_JREG)) |-> flush);

  assert_jz_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_op == OP_JZ && ex_test != '0) |-> !flush);

  assert_mem_hit_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_op == OP_COPY && mem_valid && mem_wr_en &&
     mem_dst == dec_fb && !flush) |-> (ip_hold && bubble));

endmodule

// File: tb/hazard_stall_ctrl_test.sv
module hazard_stall_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 0, ex_valid = 0, ex_wr_en = 0, mem_valid = 0, mem_wr_en = 0;
  logic [4:0] dec_op = 0, dec_fa = 0, dec_fb = 0, dec_fc = 0, ex_op = 0, ex_dst = 0, mem_dst = 0;
  logic [15:0] ex_test = 0;
  logic ip_hold, dec_hold, bubble, flush;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  hazard_stall_ctrl uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
    .dec_fa(dec_fa), .dec_fb(dec_fb), .dec_fc(dec_fc), .ex_valid(ex_valid),
    .ex_op(ex_op), .ex_wr_en(ex_wr_en), .ex_dst(ex_dst), .ex_test(ex_test),
    .mem_valid(mem_valid), .mem_wr_en(mem_wr_en), .mem_dst(mem_dst),
    .ip_hold(ip_hold), .dec_hold(dec_hold), .bubble(bubble), .flush(flush));

  // {req[4], dv, dop, fa, fb, fc, xv, xop, xw, xdst, xzero, mv, mw, mdst, exp{ihold,dhold,bubble,flush}}
  localparam int N = 28;
  localparam logic [48:0] VEC [N] = '{
    {4'd1,1'b1,5'h01,5'd1,5'd2,5'd3, 1'b1,5'h01,1'b1,5'd2,1'b0, 1'b0,1'b0,5'd0, 4'b1110}, // R1 add B vs ex
    {4'd2,1'b1,5'h01,5'd1,5'd2,5'd3, 1'b0,5'h01,1'b0,5'd0,1'b0, 1'b1,1'b1,5'd3, 4'b1110}, // R2 add C vs mem
    {4'd4,1'b1,5'h01,5'd1,5'd2,5'd3, 1'b1,5'h01,1'b1,5'd1,1'b0, 1'b0,1'b0,5'd0, 4'b0000}, // R4 dest A ignored
    {4'd3,1'b1,5'h01,5'd1,5'd2,5'd3, 1'b1,5'h01,1'b0,5'd2,1'b0, 1'b0,1'b0,5'd0, 4'b0000}, // R3 no write flag
    {4'd3,1'b1,5'h01,5'd1,5'd2,5'd3, 1'b0,5'h01,1'b1,5'd2,1'b0, 1'b1,1'b0,5'd3, 4'b0000}, // R3 stages invalid / no wr
    {4'd3,1'b0,5'h01,5'd1,5'd2,5'd3, 1'b1,5'h01,1'b1,5'd2,1'b0, 1'b1,1'b1,5'd3, 4'b0000}, // R3 decode invalid
    {4'd5,1'b1,5'h06,5'd1,5'd2,5'd3, 1'b1,5'h01,1'b1,5'd2,1'b0, 1'b1,1'b1,5'd1, 4'b0000}, // R5 load-imm
    {4'd4,1'b1,5'h05,5'd7,5'd4,5'd5, 1'b0,5'h01,1'b0,5'd0,1'b0, 1'b1,1'b1,5'd5, 4'b0000}, // R4 copy C unused
    {4'd4,1'b1,5'h05,5'd7,5'd4,5'd5, 1'b0,5'h01,1'b0,5'd0,1'b0, 1'b1,1'b1,5'd4, 4'b1110}, // R4 copy B
    {4'd4,1'b1,5'h0D,5'd7,5'd8,5'd9, 1'b1,5'h01,1'b1,5'd8,1'b0, 1'b0,1'b0,5'd0, 4'b1110}, // R4 compare B
    {4'd4,1'b1,5'h09,5'd7,5'd8,5'd9, 1'b0,5'h01,1'b0,5'd0,1'b0, 1'b1,1'b1,5'd9, 4'b1110}, // R4 compare C
    {4'd5,1'b1,5'h0E,5'd7,5'd7,5'd7, 1'b1,5'h01,1'b1,5'd7,1'b0, 1'b1,1'b1,5'd7, 4'b0000}, // R5 jump reads none
    {4'd5,1'b1,5'h0F,5'd6,5'd6,5'd11,1'b0,5'h01,1'b0,5'd0,1'b0, 1'b1,1'b1,5'd11,4'b1110}, // R5 cond jump C
    {4'd5,1'b1,5'h0F,5'd6,5'd6,5'd11,1'b1,5'h01,1'b1,5'd6,1'b0, 1'b1,1'b1,5'd6, 4'b0000}, // R5 cond jump A,B unused
    {4'd5,1'b1,5'h10,5'd6,5'd12,5'd13,1'b1,5'h01,1'b1,5'd6,1'b0, 1'b0,1'b0,5'd0, 4'b1110}, // R5 reg jump A
    {4'd5,1'b1,5'h10,5'd6,5'd12,5'd13,1'b1,5'h01,1'b1,5'd12,1'b0,1'b1,1'b1,5'd13,4'b0000}, // R5 reg jump B,C unused
    {4'd5,1'b1,5'h07,5'd14,5'd15,5'd16,1'b0,5'h01,1'b0,5'd0,1'b0, 1'b1,1'b1,5'd16,4'b1110}, // R5 mem write C
    {4'd5,1'b1,5'h07,5'd14,5'd15,5'd16,1'b1,5'h01,1'b1,5'd14,1'b0,1'b0,1'b0,5'd0, 4'b1110}, // R5 mem write A
    {4'd5,1'b1,5'h07,5'd14,5'd15,5'd16,1'b1,5'h01,1'b1,5'd15,1'b0,1'b0,1'b0,5'd0, 4'b0000}, // R5 mem write B unused
    {4'd5,1'b1,5'h08,5'd17,5'd18,5'd19,1'b1,5'h01,1'b1,5'd17,1'b0,1'b1,1'b1,5'd19,4'b0000}, // R5 mem read A dest
    {4'd5,1'b1,5'h08,5'd17,5'd18,5'd19,1'b1,5'h01,1'b1,5'd18,1'b0,1'b0,1'b0,5'd0, 4'b1110}, // R5 mem read B
    {4'd6,1'b0,5'h00,5'd0,5'd0,5'd0, 1'b1,5'h0E,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 4'b0011}, // R6 jump taken
    {4'd6,1'b0,5'h00,5'd0,5'd0,5'd0, 1'b1,5'h10,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 4'b0011}, // R6 reg jump taken
    {4'd6,1'b0,5'h00,5'd0,5'd0,5'd0, 1'b0,5'h0E,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 4'b0000}, // R6 invalid jump
    {4'd7,1'b0,5'h00,5'd0,5'd0,5'd0, 1'b1,5'h0F,1'b0,5'd0,1'b1, 1'b0,1'b0,5'd0, 4'b0011}, // R7 zero taken
    {4'd7,1'b0,5'h00,5'd0,5'd0,5'd0, 1'b1,5'h0F,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 4'b0000}, // R7 nonzero not taken
    {4'd8,1'b1,5'h01,5'd1,5'd2,5'd3, 1'b1,5'h0E,1'b0,5'd0,1'b0, 1'b1,1'b1,5'd3, 4'b0011}, // R8 flush wins
    {4'd8,1'b1,5'h05,5'd1,5'd4,5'd3, 1'b1,5'h0F,1'b0,5'd0,1'b1, 1'b1,1'b1,5'd4, 4'b0011}  // R8 cond flush wins
  };

  task automatic chk(input int req, input logic [3:0] exp);
    logic [3:0] got;
    got = {ip_hold, dec_hold, bubble, flush};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %b expected %b", req, got, exp);
    end
  endtask

  initial begin
    #20000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(3, 4'b0000); // R3 reset state
    @(posedge clk); #1 rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      logic [48:0] v;
      v = VEC[i];
      @(posedge clk); #1;
      dec_valid = v[44]; dec_op = v[43:39]; dec_fa = v[38:34]; dec_fb = v[33:29]; dec_fc = v[28:24];
      ex_valid = v[23]; ex_op = v[22:18]; ex_wr_en = v[17]; ex_dst = v[16:12];
      ex_test = v[11] ? 16'h0000 : 16'h1234;
      mem_valid = v[10]; mem_wr_en = v[9]; mem_dst = v[8:4];
      @(negedge clk);
      chk(int'(v[48:45]), v[3:0]);
    end

    // R2: writer walks ex -> mem -> write-back; stall lasts two cycles
    @(posedge clk); #1;
    dec_valid = 1; dec_op = 5'h02; dec_fa = 5'd20; dec_fb = 5'd21; dec_fc = 5'd22;
    ex_valid = 1; ex_op = 5'h01; ex_wr_en = 1; ex_dst = 5'd22; ex_test = 16'h1;
    mem_valid = 0; mem_wr_en = 0; mem_dst = 0;
    @(negedge clk); chk(1, 4'b1110);
    @(posedge clk); #1;
    ex_valid = 0; ex_wr_en = 0; ex_dst = 0;
    mem_valid = 1; mem_wr_en = 1; mem_dst = 5'd22;
    @(negedge clk); chk(2, 4'b1110);
    @(posedge clk); #1;
    mem_valid = 0; mem_wr_en = 0; mem_dst = 0;
    @(negedge clk); chk(2, 4'b0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule